// File: doc/BRIEF.md
# Iterative Circular and Hyperbolic CORDIC Engine

This block evaluates CORDIC rotations and vectorings in either the circular (trigonometric) or the hyperbolic coordinate system, using one shared shift-and-add datapath. A host loads three 30-bit operands, X, Y and the angle Z, through an addressed register port guarded by a select line. It then writes the control address with one mode line and one system line raised. Values are two's complement with 2 integer and 28 fraction bits.

The engine performs one micro-rotation per clock while `run_en` is high. Each step shifts X and Y right by the current index and adds or subtracts an angle constant taken from an elaboration-time table. Rotation steers Z toward zero. Vectoring steers Y toward zero. The circular system uses indices 0 to 27. The hyperbolic system uses indices 1 to 26, with indices 4 and 13 each applied twice, which also gives 28 steps.

`busy` stays high for the whole computation. When it drops, the results can be read back from the same addresses. The CORDIC gain is left in the results. To get unit-scaled outputs, the host preloads X with the reciprocal gain.

Top module: `cordic_engine`

## Requirements
- R1: After reset, `busy` is low and reading addresses 0, 1 and 2 returns zero.
- R2: While idle, a write with `sel` and `wr_en` at address 0, 1 or 2 stores `wdata` into X, Y or Z respectively. `rdata` returns that register while `sel` and `rd_en` are both high. Reading address 3, or holding `rd_en` low, gives zero.
- R3: A write to address 3 while idle starts a computation only when exactly one of `mode_rot`/`mode_vec` and exactly one of `sys_hyp`/`sys_circ` is high. In that case `busy` is high from the next clock. Any other combination leaves `busy` low.
- R4: While `busy` is high, bus writes to any address have no effect on X, Y, Z or the ongoing computation.
- R5: `busy` stays high for exactly 28 clock edges at which `run_en` is high. While `run_en` is low, X, Y, Z and the step position are frozen.
- R6: A circular rotation yields X = K(x·cos z − y·sin z) and Y = K(y·cos z + x·sin z), with Z near zero, where K is the product of sqrt(1+2^-2i) for i = 0..27.
- R7: A circular vectoring yields X = K·sqrt(x²+y²), with Y near zero and Z = z + atan(y/x), for x > 0.
- R8: A hyperbolic rotation yields X = K'(x·cosh z + y·sinh z) and Y = K'(y·cosh z + x·sinh z), with Z near zero. K' is the product of sqrt(1−2^-2i) over the index sequence 1,2,3,4,4,5,…,13,13,14,…,26.
- R9: A hyperbolic vectoring yields X = K'·sqrt(x²−y²), with Y near zero and Z = z + atanh(y/x), for |y| < 0.8x.
- R10: After `busy` falls, X, Y and Z hold their results until the next accepted bus write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| run_en | input | 1 | Allows one iteration per clock while busy |
| sel | input | 1 | Qualifies bus reads and writes |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| reg_addr | input | 2 | 0 = X, 1 = Y, 2 = Z, 3 = start control |
| wdata | input | 30 | Write data, Q2.28 |
| mode_rot | input | 1 | Requests rotation mode at start |
| mode_vec | input | 1 | Requests vectoring mode at start |
| sys_hyp | input | 1 | Requests hyperbolic system at start |
| sys_circ | input | 1 | Requests circular system at start |
| rdata | output | 30 | Read data, Q2.28 |
| busy | output | 1 | High while a computation is in progress |

## Verification
Two things can land on the same clock edge. One is a host write and an iteration update. The other is a pause and a completion. The bench raises both cases on purpose. It writes an operand while the engine is paused mid-run and reads it back unchanged. It issues a second start during a run. It also randomly drops `run_en` across whole computations, including around the final step. Each case is judged by counting enabled edges until `busy` falls and by comparing the read-back results with real-valued reference formulas, within a 64-LSB tolerance.

// File: rtl/cordic_engine.sv
module cordic_engine #(
  parameter int W     = 30,
  parameter int FRAC  = 28,
  parameter int STEPS = 28,
  parameter int REP_A = 4,
  parameter int REP_B = 13,
  localparam int SW   = $clog2(STEPS + 4)
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         run_en,
  input  logic         sel,
  input  logic         wr_en,
  input  logic         rd_en,
  input  logic [1:0]   reg_addr,
  input  logic [W-1:0] wdata,
  input  logic         mode_rot,
  input  logic         mode_vec,
  input  logic         sys_hyp,
  input  logic         sys_circ,
  output logic [W-1:0] rdata,
  output logic         busy
);

  function automatic logic [W-1:0] ang_const(input int i, input bit hyp);
    real x, t, s;
    x = 1.0 / (2.0 ** i);
    s = 0.0;
    t = x;
    if (!hyp && i == 0) s = 0.78539816339744831;
    else
      for (int k = 0; k < 40; k++) begin
        s = s + t / (2.0 * k + 1.0);
        t = hyp ? t * x * x : -t * x * x;
      end
    return W'($rtoi(s * (2.0 ** FRAC) + 0.5));
  endfunction

  logic signed [W-1:0] circ_tab [STEPS];
  logic signed [W-1:0] hyp_tab  [STEPS];

  for (genvar g = 0; g < STEPS; g++) begin : g_rom
    assign circ_tab[g] = ang_const(g, 1'b0);
    assign hyp_tab[g]  = ang_const(g, 1'b1);
  end

  logic signed [W-1:0] x_q, y_q, z_q;
  logic [SW-1:0]       step_q, sh_idx;
  logic                busy_q, hyp_q, vec_q;

  wire wr_hit   = sel & wr_en;
  wire start_ok = wr_hit & (reg_addr == 2'd3) & (mode_rot ^ mode_vec) & (sys_hyp ^ sys_circ);

  always_comb begin
    int k;
    k = int'(step_q);
    if (hyp_q) k = k + 1 - int'(k >= REP_A) - int'(k >= REP_B + 1);
    sh_idx = SW'(k);
  end

  wire signed [W-1:0] x_sh = x_q >>> sh_idx;
  wire signed [W-1:0] y_sh = y_q >>> sh_idx;
  wire signed [W-1:0] ang  = hyp_q ? hyp_tab[sh_idx] : circ_tab[sh_idx];
  wire                dpos = vec_q ? y_q[W-1] : ~z_q[W-1];

  wire signed [W-1:0] x_nx = (hyp_q ^ dpos) ? x_q - y_sh : x_q + y_sh;
  wire signed [W-1:0] y_nx = dpos ? y_q + x_sh : y_q - x_sh;
  wire signed [W-1:0] z_nx = dpos ? z_q - ang : z_q + ang;

  always_ff @(posedge clk) begin
    if (rst) begin
      x_q <= '0; y_q <= '0; z_q <= '0;
      step_q <= '0; busy_q <= 1'b0; hyp_q <= 1'b0; vec_q <= 1'b0;
    end else if (busy_q) begin
      if (run_en) begin
        x_q <= x_nx; y_q <= y_nx; z_q <= z_nx;
        step_q <= step_q + 1'b1;
        if (step_q == SW'(STEPS - 1)) busy_q <= 1'b0;
      end
    end else if (wr_hit) begin
      case (reg_addr)
        2'd0: x_q <= wdata;
        2'd1: y_q <= wdata;
        2'd2: z_q <= wdata;
        default: if (start_ok) begin
          busy_q <= 1'b1; step_q <= '0; hyp_q <= sys_hyp; vec_q <= mode_vec;
        end
      endcase
    end
  end

  assign busy  = busy_q;
  assign rdata = !(sel && rd_en) ? '0 :
                 reg_addr == 2'd0 ? x_q :
                 reg_addr == 2'd1 ? y_q :
                 reg_addr == 2'd2 ? z_q : '0;

  a_r5_pause_freezes: assert property (@(posedge clk) disable iff (rst)
    busy_q && !run_en |=> busy_q && $stable(x_q) && $stable(y_q) && $stable(z_q) && $stable(step_q));

  a_r5_step_in_range: assert property (@(posedge clk) disable iff (rst)
    busy_q |-> int'(step_q) < STEPS);

  a_r5_finish_on_last: assert property (@(posedge clk) disable iff (rst)
    $fell(busy_q) |-> $past(step_q) == SW'(STEPS - 1) && $past(run_en));

  a_r3_start_needs_write: assert property (@(posedge clk) disable iff (rst)
    $rose(busy_q) |-> $past(sel && wr_en && reg_addr == 2'd3));

  a_r3_bad_start_ignored: assert property (@(posedge clk) disable iff (rst)
    !busy_q && sel && wr_en && reg_addr == 2'd3 && (mode_rot == mode_vec) |=> !busy_q);

  a_r10_idle_hold: assert property (@(posedge clk) disable iff (rst)
    !busy_q && !(sel && wr_en) |=> $stable(x_q) && $stable(y_q) && $stable(z_q));

endmodule

// File: tb/cordic_engine_tb.sv
module cordic_engine_tb;
  localparam int  CLK_NS = 10;
  localparam real SC     = 268435456.0;
  localparam real TOL    = 64.0;

  logic        clk = 1'b0, rst = 1'b1, run_en = 1'b1;
  logic        sel = 1'b0, wr_en = 1'b0, rd_en = 1'b0;
  logic [1:0]  reg_addr = '0;
  logic [29:0] wdata = '0;
  logic        mode_rot = 1'b1, mode_vec = 1'b0, sys_hyp = 1'b0, sys_circ = 1'b1;
  logic [29:0] rdata;
  logic        busy;

  int  n_chk = 0, n_bad = 0;
  real kc, kh;

  always #(CLK_NS/2) clk = ~clk;

  cordic_engine u_dut (
    .clk(clk), .rst(rst), .run_en(run_en), .sel(sel), .wr_en(wr_en), .rd_en(rd_en),
    .reg_addr(reg_addr), .wdata(wdata), .mode_rot(mode_rot), .mode_vec(mode_vec),
    .sys_hyp(sys_hyp), .sys_circ(sys_circ), .rdata(rdata), .busy(busy)
  );

  task automatic check_eq(input string tag, input logic [29:0] got, input logic [29:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic check_near(input string tag, input logic signed [29:0] got, input real exp);
    real d;
    int  gi;
    gi = got;
    d = $itor(gi) - exp * SC;
    n_chk++;
    if (d > TOL || d < -TOL) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0.1f", tag, gi, exp * SC);
    end
  endtask

  task automatic bus_write(input logic [1:0] a, input logic [29:0] d);
    @(negedge clk);
    sel = 1'b1; wr_en = 1'b1; reg_addr = a; wdata = d;
    @(negedge clk);
    sel = 1'b0; wr_en = 1'b0;
  endtask

  task automatic bus_read(input logic [1:0] a, output logic [29:0] d);
    @(negedge clk);
    sel = 1'b1; rd_en = 1'b1; reg_addr = a;
    #1 d = rdata;
    sel = 1'b0; rd_en = 1'b0;
  endtask

  function automatic real rnd(input real lo, input real hi);
    return lo + (hi - lo) * $itor($urandom % 100000) / 100000.0;
  endfunction

  task automatic run_op(input bit hyp, input bit vec, input real xr, input real yr,
                        input real zr, input bit jitter, input bit poke);
    int xi, yi, zi, cnt, guard;
    real xf, yf, zf, ex, ey, ez;
    logic [29:0] xo, yo, zo, t0, t1;
    string tg;
    xi = $rtoi(xr * SC); yi = $rtoi(yr * SC); zi = $rtoi(zr * SC);
    xf = $itor(xi) / SC; yf = $itor(yi) / SC; zf = $itor(zi) / SC;
    bus_write(2'd0, xi[29:0]);
    bus_write(2'd1, yi[29:0]);
    bus_write(2'd2, zi[29:0]);
    mode_rot = !vec; mode_vec = vec; sys_hyp = hyp; sys_circ = !hyp;
    bus_write(2'd3, '0);
    check_eq("R3 busy after start", {29'd0, busy}, 30'd1);
    cnt = 0; guard = 0;
    while (busy && guard < 5000) begin
      guard++;
      run_en = jitter ? ($urandom % 4 != 0) : 1'b1;
      if (poke && guard == 5) begin
        run_en = 1'b0;
        bus_read(2'd0, t0);
        @(negedge clk);
        sel = 1'b1; wr_en = 1'b1; reg_addr = 2'd0; wdata = 30'h0ABCDEF;
        @(negedge clk);
        sel = 1'b1; reg_addr = 2'd3;
        @(negedge clk);
        sel = 1'b0; wr_en = 1'b0;
        bus_read(2'd0, t1);
        check_eq("R4 write ignored while busy", t1, t0);
        check_eq("R5 paused keeps busy", {29'd0, busy}, 30'd1);
      end
      @(negedge clk);
      if (run_en) cnt++;
    end
    run_en = 1'b1;
    check_eq("R5 enabled edges while busy", 30'(cnt), 30'd28);
    bus_read(2'd0, xo); bus_read(2'd1, yo); bus_read(2'd2, zo);
    if (!hyp && !vec) begin
      tg = "R6";
      ex = kc * (xf * $cos(zf) - yf * $sin(zf)); ey = kc * (yf * $cos(zf) + xf * $sin(zf)); ez = 0.0;
    end else if (!hyp) begin
      tg = "R7";
      ex = kc * $sqrt(xf * xf + yf * yf); ey = 0.0; ez = zf + $atan(yf / xf);
    end else if (!vec) begin
      tg = "R8";
      ex = kh * (xf * $cosh(zf) + yf * $sinh(zf)); ey = kh * (yf * $cosh(zf) + xf * $sinh(zf)); ez = 0.0;
    end else begin
      tg = "R9";
      ex = kh * $sqrt(xf * xf - yf * yf); ey = 0.0; ez = zf + $atanh(yf / xf);
    end
    check_near({tg, " X"}, xo, ex);
    check_near({tg, " Y"}, yo, ey);
    check_near({tg, " Z"}, zo, ez);
    repeat (5) @(negedge clk);
    bus_read(2'd0, t0);
    check_eq("R10 X held after done", t0, xo);
  endtask

  initial begin
    logic [29:0] r;
    void'($urandom(32'h5EED_0042));
    kc = 1.0;
    for (int i = 0; i < 28; i++) kc = kc * $sqrt(1.0 + 1.0 / (4.0 ** i));
    kh = 1.0;
    for (int s = 0; s < 28; s++) begin
      int k;
      k = s + 1 - ((s >= 4) ? 1 : 0) - ((s >= 14) ? 1 : 0);
      kh = kh * $sqrt(1.0 - 1.0 / (4.0 ** k));
    end
    repeat (3) @(negedge clk);
    rst = 1'b0;

    check_eq("R1 busy after reset", {29'd0, busy}, 30'd0);
    for (int a = 0; a < 3; a++) begin
      bus_read(2'(a), r);
      check_eq("R1 register zero after reset", r, '0);
    end

    bus_write(2'd0, 30'h2000_0001); bus_write(2'd1, 30'h1FFF_FFFF); bus_write(2'd2, 30'h0555_AAAA);
    bus_read(2'd0, r); check_eq("R2 X readback", r, 30'h2000_0001);
    bus_read(2'd1, r); check_eq("R2 Y readback", r, 30'h1FFF_FFFF);
    bus_read(2'd2, r); check_eq("R2 Z readback", r, 30'h0555_AAAA);
    bus_read(2'd3, r); check_eq("R2 control reads zero", r, '0);
    @(negedge clk); sel = 1'b1; rd_en = 1'b0; reg_addr = 2'd0;
    #1 check_eq("R2 no read strobe gives zero", rdata, '0);
    sel = 1'b0;

    mode_rot = 1'b1; mode_vec = 1'b1; sys_hyp = 1'b0; sys_circ = 1'b1;
    bus_write(2'd3, '0);
    check_eq("R3 both mode lines rejected", {29'd0, busy}, 30'd0);
    mode_rot = 1'b1; mode_vec = 1'b0; sys_hyp = 1'b0; sys_circ = 1'b0;
    bus_write(2'd3, '0);
    check_eq("R3 no system line rejected", {29'd0, busy}, 30'd0);
    bus_read(2'd0, r); check_eq("R3 rejected start leaves X", r, 30'h2000_0001);

    run_op(1'b0, 1'b0, 0.6, 0.0, 0.0, 1'b0, 1'b0);
    run_op(1'b0, 1'b0, 0.5, -0.3, 1.5, 1'b0, 1'b1);
    run_op(1'b0, 1'b1, 0.4, 0.0, 0.05, 1'b0, 1'b0);
    run_op(1'b1, 1'b0, 0.4, 0.1, 1.0, 1'b0, 1'b0);
    run_op(1'b1, 1'b0, 0.3, -0.2, -0.9, 1'b1, 1'b1);
    run_op(1'b1, 1'b1, 0.5, 0.34, 0.0, 1'b0, 1'b0);

    for (int n = 0; n < 40; n++) begin
      int  m;
      real x, y, z;
      m = $urandom % 4;
      case (m)
        0: begin x = rnd(-0.6, 0.6); y = rnd(-0.6, 0.6); z = rnd(-1.5, 1.5); end
        1: begin x = rnd(0.1, 0.6);  y = rnd(-0.6, 0.6); z = rnd(-0.1, 0.1); end
        2: begin x = rnd(0.2, 0.5);  y = rnd(-0.3, 0.3); z = rnd(-1.0, 1.0); end
        default: begin x = rnd(0.3, 0.7); y = x * rnd(-0.7, 0.7); z = rnd(-0.2, 0.2); end
      endcase
      run_op(m >= 2, m[0], x, y, z, n[0], 1'b0);
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(CLK_NS * 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule